// File: doc/BRIEF.md
# External Interrupt Sensitivity Controller

This block sits between package pins and an interrupt controller. It turns twelve asynchronous pin inputs into four interrupt requests. The pins fall into four groups: four pins on port A, three on port F, four low pins on port B and the single fifth pin of port B. One 8-bit configuration register sets how each group reacts: to a falling edge combined with a low level, to one edge only, or to both edges. Two of the groups also have a polarity-inversion bit. Software may change the register only while the processor runs at the highest interrupt level (level 3). A write at any lower level is dropped without effect.

Every pin passes through a two-flop synchronizer. Edges are found on the polarity-corrected value of each pin, and the per-pin events of a group are ORed together. An edge event sets a sticky pending flag, which stays set until the matching acknowledge input pulses. In the level-plus-edge mode, the request also stays high for as long as any pin of the group sits at its active level.

The block carries no data stream. Every port is a plain control or status signal, so there is no valid/ready handshake and no back-pressure. A register write is a one-cycle strobe that completes in the cycle it is presented.

Top module: `extint_sense_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x00. Bits 1:0 always read 0, whatever value is written to them.
- R2: A write (`reg_wr_en` = 1) updates bits 7:2 only when `cpu_lvl` = 2'b11. At any other level the register keeps its value.
- R3: Code 2'b00 requests on a falling pin edge and while a pin is low. With the group's inversion bit at 1, it requests on a rising edge and while a pin is high.
- R4: Code 2'b01 reacts to rising edges only, and to falling edges only when inverted. Code 2'b10 reacts to falling edges only, and to rising edges only when inverted.
- R5: Code 2'b11 reacts to both edges, and the inversion bit does not change that.
- R6: Request bit `irq_req[i]` belongs to group i:
  - group 0 is `pa_pins[3:0]`, with code in bits 4:3 and inversion in bit 2;
  - group 1 is `pf_pins[2:0]`, with code in bits 4:3 and no inversion;
  - group 2 is `pb_pins[3:0]`, with code in bits 7:6 and inversion in bit 5;
  - group 3 is `pb_pins[4]`, with code in bits 7:6 and no inversion.
- R7: An edge event sets a sticky pending flag that holds the request high. A pulse on `irq_ack[i]` clears it. A new event in the same cycle as the acknowledge wins.
- R8: In code 2'b00, the request stays high for as long as any pin of the group is at the active level, even after an acknowledge.
- R9: Changing a group's code or inversion bit never creates an edge event by itself.
- R10: A pin edge that meets the setup time before a rising clock edge raises the request right after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | One-cycle write strobe for the configuration register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current configuration register value |
| cpu_lvl | input | 2 | Current interrupt level of the processor; writes need 2'b11 |
| pa_pins | input | 4 | Port A pins, group 0 |
| pb_pins | input | 5 | Port B pins: bits 3:0 are group 2, bit 4 is group 3 |
| pf_pins | input | 3 | Port F pins, group 1 |
| irq_ack | input | 4 | Per-group acknowledge pulse that clears the pending flag |
| irq_req | output | 4 | Per-group interrupt request |

## Verification
The embedded assertions check these properties on every cycle:
- writes are locked outside level 3, and a level-3 write stores the masked data;
- a detected edge sets the pending flag on the next cycle;
- an acknowledge with no competing event clears the pending flag;
- an active level in the combined mode forces the request high;
- both-edge mode catches every edge;
- a configuration change never sets the pending flag.

Some behaviour only the bench's scenarios can show. One is the exact three-edge latency through the synchronizer. Another is the mapping of each register field to the right pin group and request bit. The bench also checks every code under both polarities against a reference model, over a random mix of pin changes, acknowledges and locked or unlocked writes.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int NGRP        = 4;
  localparam int SYNC_STAGES = 2;
  localparam int CFG_W       = 8;
  localparam int RSVD_W      = 2;
  localparam int LVL_W       = 2;
  localparam int PA_W        = 4;
  localparam int PB_W        = 5;
  localparam int PF_W        = 3;
  localparam int PIN_TOTAL   = PA_W + PB_W + PF_W;

  // field positions decoded by the group logic
  localparam int CODE_LO_POS = 3;  // groups 0 and 1
  localparam int CODE_HI_POS = 6;  // groups 2 and 3
  localparam int INV_A_POS   = 2;  // group 0
  localparam int INV_B_POS   = 5;  // group 2

  typedef enum logic [1:0] {
    SENS_FALL_LOW = 2'b00,
    SENS_RISE     = 2'b01,
    SENS_FALL     = 2'b10,
    SENS_BOTH     = 2'b11
  } sens_e;

  // group order in the packed pin vector: A, F, B[3:0], B[4]
  function automatic int grp_width(int g);
    case (g)
      0:       return PA_W;
      1:       return PF_W;
      2:       return PB_W - 1;
      default: return 1;
    endcase
  endfunction

  function automatic int grp_offset(int g);
    int acc;
    acc = 0;
    for (int k = 0; k < g; k++) acc += grp_width(k);
    return acc;
  endfunction
endpackage

// File: rtl/extint_cfg_reg.sv
module extint_cfg_reg
  import extint_pkg::*;
#(
  parameter int DW   = CFG_W,
  parameter int RSVD = RSVD_W,
  parameter int LW   = LVL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [LW-1:0] lvl,
  output logic [DW-1:0] cfg_q
);
  localparam logic [DW-1:0] WMASK   = {{(DW-RSVD){1'b1}}, {RSVD{1'b0}}};
  localparam logic [LW-1:0] TOP_LVL = {LW{1'b1}};

  logic wr_ok;
  assign wr_ok = wr_en && (lvl == TOP_LVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_ok) cfg_q <= wdata & WMASK;
  end

  // R2
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lvl != TOP_LVL) |=> $stable(cfg_q));

  // R2
  cfg_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lvl == TOP_LVL) |=> (cfg_q == ($past(wdata) & WMASK)));
endmodule

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/extint_group.sv
module extint_group
  import extint_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         armed,
  input  logic [W-1:0] pins,
  input  sens_e        mode,
  input  logic         inv,
  input  logic         ack,
  output logic         irq
);
  logic [W-1:0] eff, prev;
  logic [2:0]   cfg_seen;
  logic         cfg_chg, reload, rise, fall, rise_en, fall_en;
  logic         evt, lvl_hit, pending;

  // polarity-corrected pin value: inversion swaps the meaning of edges/levels
  assign eff     = pins ^ {W{inv}};
  assign cfg_chg = cfg_seen != {mode, inv};
  assign reload  = !armed || cfg_chg;

  assign rise = |(eff & ~prev);
  assign fall = |(~eff & prev);

  always_comb begin
    rise_en = 1'b0;
    fall_en = 1'b0;
    case (mode)
      SENS_FALL_LOW: fall_en = 1'b1;
      SENS_RISE:     rise_en = 1'b1;
      SENS_FALL:     fall_en = 1'b1;
      default: begin
        rise_en = 1'b1;
        fall_en = 1'b1;
      end
    endcase
  end

  assign evt     = !reload && ((rise_en && rise) || (fall_en && fall));
  assign lvl_hit = (mode == SENS_FALL_LOW) && !(&eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev     <= '0;
      cfg_seen <= 3'b000;
      pending  <= 1'b0;
    end else begin
      prev     <= eff;
      cfg_seen <= {mode, inv};
      if (evt)      pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end

  assign irq = pending | lvl_hit;

  // R7
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pending);

  // R7
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !evt) |=> !pending);

  // R8
  lvl_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENS_FALL_LOW && !(&eff)) |-> irq);

  // R5
  both_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENS_BOTH && !reload && eff != prev) |=> pending);

  // R9
  no_false_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chg && !pending) |=> !pending);
endmodule

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl
  import extint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [CFG_W-1:0]  reg_wdata,
  output logic [CFG_W-1:0]  reg_rdata,
  input  logic [LVL_W-1:0]  cpu_lvl,
  input  logic [PA_W-1:0]   pa_pins,
  input  logic [PB_W-1:0]   pb_pins,
  input  logic [PF_W-1:0]   pf_pins,
  input  logic [NGRP-1:0]   irq_ack,
  output logic [NGRP-1:0]   irq_req
);
  localparam int ARM_CNT = SYNC_STAGES + 1;
  localparam int ARM_W   = $clog2(ARM_CNT + 1);

  logic [CFG_W-1:0]     cfg;
  logic [PIN_TOTAL-1:0] pin_all, pin_sync;
  logic [ARM_W-1:0]     arm_cnt;
  logic                 armed;

  extint_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .wdata (reg_wdata),
    .lvl   (cpu_lvl),
    .cfg_q (cfg)
  );
  assign reg_rdata = cfg;

  assign pin_all = {pb_pins[PB_W-1], pb_pins[PB_W-2:0], pf_pins, pa_pins};

  extint_sync #(.W(PIN_TOTAL), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_all),
    .dout  (pin_sync)
  );

  // hold off edge detection until the synchronizer holds real pin values
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_cnt <= '0;
    else if (!armed) arm_cnt <= arm_cnt + 1'b1;
  end
  assign armed = (arm_cnt == ARM_W'(ARM_CNT));

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int W   = grp_width(g);
    localparam int OFS = grp_offset(g);
    localparam int CP  = (g < 2) ? CODE_LO_POS : CODE_HI_POS;
    sens_e mode;
    logic  inv;

    assign mode = sens_e'(cfg[CP+1:CP]);
    if (g == 0) begin : g_inv_a
      assign inv = cfg[INV_A_POS];
    end else if (g == 2) begin : g_inv_b
      assign inv = cfg[INV_B_POS];
    end else begin : g_no_inv
      assign inv = 1'b0;
    end

    extint_group #(.W(W)) u_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .armed (armed),
      .pins  (pin_sync[OFS+W-1:OFS]),
      .mode  (mode),
      .inv   (inv),
      .ack   (irq_ack[g]),
      .irq   (irq_req[g])
    );
  end
endmodule

// File: tb/extint_sense_ctrl_bench.sv
module extint_sense_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] cpu_lvl = '0;
  logic [3:0] pa_pins = '0;
  logic [4:0] pb_pins = '0;
  logic [2:0] pf_pins = '0;
  logic [3:0] irq_ack = '0;
  logic [3:0] irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] cfg_m = 8'h00;
  logic [3:0] pend_m = 4'h0;

  always #10 clk = ~clk;

  extint_sense_ctrl u_extint_sense_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_lvl(cpu_lvl), .pa_pins(pa_pins), .pb_pins(pb_pins),
    .pf_pins(pf_pins), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  // polarity-corrected group value, unused lanes padded inactive (high)
  function automatic logic [3:0] eff_of(int g, logic [3:0] a, logic [4:0] b,
                                        logic [2:0] f, logic [7:0] c);
    case (g)
      0:       return a ^ {4{c[2]}};
      1:       return {1'b1, f};
      2:       return b[3:0] ^ {4{c[5]}};
      default: return {3'b111, b[4]};
    endcase
  endfunction

  function automatic logic [1:0] code_of(int g, logic [7:0] c);
    return (g < 2) ? c[4:3] : c[7:6];
  endfunction

  function automatic logic evt_of(logic [1:0] code, logic [3:0] o, logic [3:0] n);
    logic r, fl;
    r  = |(n & ~o);
    fl = |(~n & o);
    case (code)
      2'b01:   return r;
      2'b11:   return r | fl;
      default: return fl;
    endcase
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] v;
    for (int g = 0; g < 4; g++)
      v[g] = pend_m[g] |
             ((code_of(g, cfg_m) == 2'b00) && (eff_of(g, pa_pins, pb_pins, pf_pins, cfg_m) != 4'hF));
    return v;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step_pins(string tag, logic [3:0] a, logic [4:0] b, logic [2:0] f);
    for (int g = 0; g < 4; g++)
      if (evt_of(code_of(g, cfg_m), eff_of(g, pa_pins, pb_pins, pf_pins, cfg_m),
                 eff_of(g, a, b, f, cfg_m)))
        pend_m[g] = 1'b1;
    pa_pins = a; pb_pins = b; pf_pins = f;
    repeat (4) @(negedge clk);
    chk(tag, {4'h0, irq_req}, {4'h0, exp_irq()});
  endtask

  task automatic do_write(string tag, logic [7:0] d, logic [1:0] l);
    reg_wdata = d; cpu_lvl = l; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (l == 2'b11) cfg_m = d & 8'hFC;
    repeat (2) @(negedge clk);
    chk({tag, " rdata"}, reg_rdata, cfg_m);
    chk({tag, " irq"}, {4'h0, irq_req}, {4'h0, exp_irq()});
  endtask

  task automatic do_ack(string tag, logic [3:0] m);
    irq_ack = m;
    @(negedge clk);
    irq_ack = '0;
    pend_m = pend_m & ~m;
    chk(tag, {4'h0, irq_req}, {4'h0, exp_irq()});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset value; R3/R8 default code 00 with all pins low asserts every request
    chk("R1 reset rdata", reg_rdata, 8'h00);
    chk("R8 reset level irq", {4'h0, irq_req}, 8'h0F);

    // R2 locked levels
    do_write("R2 lvl0", 8'hFF, 2'b00);
    do_write("R2 lvl2", 8'hD8, 2'b10);
    // R1 reserved bits read zero
    do_write("R1 rsvd", 8'hFF, 2'b11);

    // R5 both edges with inversion set, then R10 latency
    do_write("R5 cfg", 8'hFC, 2'b11);
    do_ack("R7 ack all", 4'hF);
    pa_pins = 4'h1;
    repeat (2) @(negedge clk);
    chk("R10 not after 2 edges", {4'h0, irq_req}, 8'h00);
    @(negedge clk);
    chk("R10 after 3 edges", {4'h0, irq_req}, 8'h01);
    pend_m[0] = 1'b1;
    do_ack("R7 ack clears", 4'h1);
    step_pins("R5 inverted fall", 4'h0, 5'h00, 3'h0);
    do_ack("R7 ack", 4'h1);

    // R9 toggle inversion on group 0 in rising mode with pins low
    do_write("R9 cfg rise", 8'h08, 2'b11);
    do_write("R9 flip inv", 8'h0C, 2'b11);
    do_write("R9 flip back", 8'h08, 2'b11);

    // R6 field-to-group mapping: B code rise, A/F code fall
    do_write("R6 cfg", 8'h50, 2'b11);
    step_pins("R6 pb4 rise", 4'h0, 5'h10, 3'h0);
    step_pins("R6 pf fall ignored", 4'h0, 5'h10, 3'h4);
    step_pins("R6 pf fall", 4'h0, 5'h10, 3'h0);
    step_pins("R4 pa rise ignored", 4'h8, 5'h10, 3'h0);
    do_ack("R6 ack", 4'hF);

    // R8 level persists through acknowledge; R3 inverted high level
    do_write("R3 cfg inv", 8'h24, 2'b11);
    step_pins("R3 high level", 4'h0, 5'h01, 3'h7);
    do_ack("R8 ack with level", 4'hF);

    for (int i = 0; i < 400; i++) begin
      r = $urandom % 8;
      if (r < 4) begin
        step_pins("R3/R4/R5/R6 rand pins", 4'($urandom), 5'($urandom), 3'($urandom));
      end else if (r < 6) begin
        do_ack("R7 rand ack", 4'($urandom));
      end else begin
        logic [1:0] l;
        l = ($urandom % 2 == 0) ? 2'b11 : 2'($urandom);
        do_write("R2/R9 rand write", 8'($urandom), l);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule